// File: doc/BRIEF.md
# Unrolled Pipelined Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands with the classic shift-and-add loop. The loop is not run in time on one adder. It is spread across a chain of 32 identical registered step stages. In each stage, the running sum takes the multiplicand when the multiplier's lowest bit is set. The multiplicand then moves up one bit and the multiplier moves down one bit. The stage registers all three values, together with a valid flag.

A new operand pair may be offered on every clock cycle. Each transaction moves one stage per cycle, so up to 32 independent products are in flight at once and one result leaves per cycle. The result is the low 32 bits of the product. There is no stall input: a producer raises `in_valid` with its operands and takes `out_prod` in the cycle in which `out_valid` is high.

The block has no state machine. The only control state is the per-stage valid flag. It has two values, empty and occupied. An asynchronous active-low reset forces every flag to empty. The transition from empty to occupied happens when the upstream flag is set at a clock edge. The transition from occupied to empty happens when the upstream flag is clear at a clock edge.

Top module: `mul_unrolled`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals (a × b) mod 2^32 for the operand pair that entered 32 cycles earlier.
- R2: `out_valid` is high in the cycle exactly 32 clock edges after the edge that sampled `in_valid` high, and not one cycle earlier.
- R3: Operand pairs offered on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly 32 cycles later, even when it sits between valid transactions.
- R5: While `rst_n` is low, `out_valid` is low. Every transaction in flight when reset is applied is discarded, so no `out_valid` pulse comes from it afterwards.
- R6: Product bits above bit 31 are dropped. For example, 0xFFFFFFFF × 0xFFFFFFFF gives 0x00000001 and 0x00010000 × 0x00010000 gives 0.
- R7: If either operand is zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every stage's valid flag |
| in_valid | input | 1 | An operand pair is present this cycle |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier |
| out_valid | output | 1 | `out_prod` holds a finished product |
| out_prod | output | 32 | Low 32 bits of the product |

## Verification
Small operands show whether the conditional add follows the lowest multiplier bit. Single set bits at the top and bottom of either operand show that each shift goes in the right direction and uses the right stage count. All-ones operands and power-of-two pairs whose product reaches 2^32 separate correct truncation from carries that leak or are lost. Zero operands show that the sum starts cleared. The table is streamed back to back, then interleaved with idle cycles, then cut by a reset in mid-flight, which checks ordering, the bubble position and the discarding of in-flight work.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;
    // Operand and product width; the step count follows from it.
    localparam int unsigned DEF_W = 32;
endpackage

// File: rtl/mul_partial.sv
// Combinational core of one iteration: conditional add plus both shifts.
module mul_partial #(
    parameter int unsigned W = mulpipe_pkg::DEF_W
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] acc_n,
    output logic [W-1:0] mcand_n,
    output logic [W-1:0] mplier_n
);
    always_comb begin
        acc_n    = mplier_i[0] ? (acc_i + mcand_i) : acc_i;
        mcand_n  = {mcand_i[W-2:0], 1'b0};
        mplier_n = {1'b0, mplier_i[W-1:1]};
    end
endmodule

// File: rtl/mul_step.sv
// One registered iteration of the shift-add loop.
module mul_step #(
    parameter int unsigned W = mulpipe_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         vld_o,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] mcand_o,
    output logic [W-1:0] mplier_o
);
    logic [W-1:0] acc_n, mcand_n, mplier_n;

    mul_partial #(.W(W)) u_partial (
        .acc_i   (acc_i),
        .mcand_i (mcand_i),
        .mplier_i(mplier_i),
        .acc_n   (acc_n),
        .mcand_n (mcand_n),
        .mplier_n(mplier_n)
    );

    // Occupancy flag: the only reset state in the stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Data registers carry no reset; bubbles move them along harmlessly.
    always_ff @(posedge clk) begin
        acc_o    <= acc_n;
        mcand_o  <= mcand_n;
        mplier_o <= mplier_n;
    end

    // acc + mcand*mplier (mod 2^W) is conserved across every step.
    logic [W-1:0] inv_in, inv_out;
    assign inv_in  = acc_i + mcand_i * mplier_i;
    assign inv_out = acc_o + mcand_o * mplier_o;

    a_r1_sum_invariant: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (inv_out == $past(inv_in)));

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (vld_o == $past(vld_i)));
endmodule

// File: rtl/mul_unrolled.sv
// Fully unrolled, fully pipelined unsigned shift-add multiplier.
module mul_unrolled #(
    parameter int unsigned W = mulpipe_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_prod
);
    localparam int unsigned STAGES = W;
    localparam int unsigned CW     = $clog2(STAGES + 1);

    logic         vld    [0:STAGES];
    logic [W-1:0] acc    [0:STAGES];
    logic [W-1:0] mcand  [0:STAGES];
    logic [W-1:0] mplier [0:STAGES];

    assign vld[0]    = in_valid;
    assign acc[0]    = '0;
    assign mcand[0]  = in_a;
    assign mplier[0] = in_b;

    for (genvar i = 0; i < STAGES; i++) begin : g_step
        mul_step #(.W(W)) u_step (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (vld[i]),
            .acc_i   (acc[i]),
            .mcand_i (mcand[i]),
            .mplier_i(mplier[i]),
            .vld_o   (vld[i+1]),
            .acc_o   (acc[i+1]),
            .mcand_o (mcand[i+1]),
            .mplier_o(mplier[i+1])
        );
    end

    assign out_valid = vld[STAGES];
    assign out_prod  = acc[STAGES];

    // Edges seen since reset release, saturating at the pipeline depth.
    logic [CW-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          since_rst <= '0;
        else if (since_rst < CW'(STAGES))    since_rst <= since_rst + 1'b1;
    end

    a_r5_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(STAGES)) |-> !out_valid);

    // After all steps, every multiplier bit and every multiplicand bit has been shifted out.
    a_r1_operands_drained: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mplier[STAGES] == '0 && mcand[STAGES] == '0));
endmodule

// File: tb/test_mul_unrolled.sv
`timescale 1ns/1ps
module test_mul_unrolled;
    localparam int LAT = 32;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid;
    logic [31:0] out_prod;

    always #2.5 clk = ~clk;

    mul_unrolled i_mul_unrolled (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    // {a, b, expected product, requirement}
    localparam logic [127:0] VEC [NV] = '{
        {32'h00000003, 32'h00000005, 32'h0000000F, 32'd1},
        {32'h00000000, 32'hDEADBEEF, 32'h00000000, 32'd7},
        {32'h12345678, 32'h00000000, 32'h00000000, 32'd7},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'd6},
        {32'h00010000, 32'h00010000, 32'h00000000, 32'd6},
        {32'h12345678, 32'h00000001, 32'h12345678, 32'd1},
        {32'h00000001, 32'h80000000, 32'h80000000, 32'd1},
        {32'h0000FFFF, 32'h0000FFFF, 32'hFFFE0001, 32'd1},
        {32'h00000007, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'd6},
        {32'd123456,   32'd1000,     32'd123456000, 32'd1},
        {32'h80000000, 32'h00000002, 32'h00000000, 32'd6},
        {32'hAAAAAAAA, 32'h00000003, 32'hFFFFFFFE, 32'd6}
    };

    int checks = 0, fails = 0, it = 0;
    logic        exp_v [64];
    logic [31:0] exp_p [64];
    int          exp_r [64];

    task automatic clear_exp();
        for (int k = 0; k < 64; k++) begin exp_v[k] = 1'b0; exp_p[k] = '0; exp_r[k] = 4; end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next input.
    task automatic tick(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] p, input int req);
        int s, ns;
        @(negedge clk);
        s = it % 64;
        checks++;
        if (out_valid !== exp_v[s]) begin
            fails++;
            $display("FAIL R%0d/R2: out_valid=%b expected %b at step %0d", exp_r[s], out_valid, exp_v[s], it);
        end
        if (exp_v[s]) begin
            checks++;
            if (out_prod !== exp_p[s]) begin
                fails++;
                $display("FAIL R%0d: out_prod=%h expected %h at step %0d", exp_r[s], out_prod, exp_p[s], it);
            end
        end
        in_valid = v; in_a = a; in_b = b;
        ns = (it + LAT) % 64;
        exp_v[ns] = v && rst_n; exp_p[ns] = p; exp_r[ns] = v ? req : 4;
        it++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 32'h5A5A5A5A, 32'hA5A5A5A5, '0, 4); // R4 bubble
    endtask

    task automatic send(input int idx, input int req_override);
        tick(1'b1, VEC[idx][127:96], VEC[idx][95:64], VEC[idx][63:32],
             (req_override != 0) ? req_override : int'(VEC[idx][31:0]));
    endtask

    // Reset for n cycles; R5: out_valid stays low and in-flight work is dropped.
    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        clear_exp();
        it++;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R5: out_valid=%b expected 0 during reset", out_valid);
            end
            it++;
        end
        rst_n = 1'b1;
    endtask

    bit finished = 0;

    initial begin
        clear_exp();
        do_reset(4);                               // R5 reset state
        idle(LAT + 2);                             // R5 nothing emerges after release
        for (int k = 0; k < NV; k++) send(k, 0);   // R1 R3 R6 R7 back to back
        for (int k = 0; k < NV; k++) begin         // R4 R2 interleaved bubbles
            send(k, (k % 2 == 0) ? 2 : 0);
            if (k % 3 == 0) idle(2); else idle(1);
        end
        idle(LAT + 2);
        for (int k = 0; k < 6; k++) send(k, 5);    // R5 mid-flight reset discards these
        do_reset(3);
        idle(LAT + 4);
        send(3, 6);                                // recovery after reset, R6
        send(7, 3);                                // R3
        idle(LAT + 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule